// File: doc/BRIEF.md
# Flash Read-Mode and Status Controller

This block is the read-path control of a NOR-style flash command interface. Command writes are decoded into a read mode: either the stub array word passes through to the data output, or a status byte is shown. A status-read command selects status output at once. Word program, block erase and block lock are two-write sequences: a setup code, then one more write. When the second write lands, the block switches to status output on its own. It stays there until another recognised mode command arrives.

The status byte has four parts. A ready bit is the inverse of the busy input. Two suspend flags and a buffered-program flag are taken live from inputs. Four sticky error bits are set by pulse inputs and cleared by a dedicated command. What the host sees is a snapshot of that byte, and it refreshes only on particular control-pin edges.

In asynchronous mode the snapshot is taken when a read access begins. Inside an asynchronous page, only word zero carries status; the other words return a fixed filler. In synchronous mode the snapshot refreshes when chip enable or address valid falls. A burst started by address valid holds the same word on the output for a parameterised number of clocks and then flags completion. The flash array, program and erase timing, and supply sensing are outside the block; plain input flags stand in for them.

Top module: `flash_rdctl`

## Requirements
- R1: After reset the read mode is array (`status_mode` = 0), no burst is active, and the status snapshot is 0x80 (ready, no errors, no suspends).
- R2: Writing 0x70 switches to status mode and writing 0xFF switches to array mode, from either mode, whenever no two-write sequence is pending.
- R3: A write of 0x40 (program), 0x20 (erase) or 0x60 (lock setup) leaves the mode unchanged. The next write of any value completes the sequence and selects status mode.
- R4: Any other code, including 0x50 (clear status), leaves the read mode unchanged.
- R5: Status byte layout: bit 7 = not busy, bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = supply error, bit 2 = program suspended, bit 1 = lock error, bit 0 = buffered-program flag. In status mode `data_out` = {zeros, snapshot}.
- R6: Error bits 5, 4, 3 and 1 are sticky. Each is set by a one-cycle pulse on its set input and cleared to 0 by command 0x50. A set in the same cycle as a clear wins.
- R7: In asynchronous mode (`sync_mode` = 0) the snapshot is refreshed at the first clock at which `ce_n` or `oe_n` is seen low after both were high. A later fall of the other pin within the same access does not refresh it.
- R8: In asynchronous mode, status mode with a nonzero `page_idx` drives PAGE_FILL (default all ones) on `data_out`.
- R9: In synchronous mode the snapshot refreshes only on a fall of `ce_n` or `adv_n`. `page_idx` is ignored there.
- R10: In synchronous mode a fall of `adv_n` while `ce_n` is low starts a burst. `burst_active` is high for BURST_LEN clocks and `burst_done` then pulses for one clock. The output word does not change during the burst.
- R11: `ce_n` rising during a burst ends it without a `burst_done` pulse.
- R12: In array mode `data_out` equals `array_data` regardless of `page_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_data | input | 8 | Command code or sequence data |
| busy_in | input | 1 | Program/erase engine busy |
| erase_susp_in | input | 1 | Erase suspend in effect |
| prog_susp_in | input | 1 | Program suspend in effect |
| bufprog_in | input | 1 | Buffered-program status flag |
| erase_err_set | input | 1 | Pulse: set erase error |
| prog_err_set | input | 1 | Pulse: set program error |
| vpp_err_set | input | 1 | Pulse: set supply error |
| lock_err_set | input | 1 | Pulse: set block-locked error |
| sync_mode | input | 1 | 1 = synchronous burst reads, 0 = asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| page_idx | input | PAGE_W | Word index within an asynchronous page |
| array_data | input | DATA_W | Stub array read word |
| data_out | output | DATA_W | Read data |
| status_mode | output | 1 | 1 = status read mode |
| burst_active | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle pulse when a burst expires |

## Verification
A sequence decoder stuck in a pending state would show up on `status_mode` one clock after the following write. A wrong mode shows up on `data_out` in the same cycle. A snapshot refreshed on the wrong edge shows as a status byte that follows input flags it should have ignored, visible one clock after the edge. An off-by-one in the burst counter shifts the `burst_done` pulse by one clock at the end of a burst of BURST_LEN cycles, so the bench counts active cycles exactly. The bench sweeps every command code from both modes and every combination of live flags.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_WORD_PROG    = 8'h40;
    localparam logic [7:0] CMD_BLOCK_ERASE  = 8'h20;
    localparam logic [7:0] CMD_LOCK_SETUP   = 8'h60;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;

    localparam int STAT_W = 8;
    localparam int ERR_N  = 4;

    typedef enum logic {
        MODE_ARRAY  = 1'b0,
        MODE_STATUS = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PROG,
        SEQ_ERASE,
        SEQ_LOCK
    } seq_state_e;

    typedef struct packed {
        logic ready;
        logic erase_susp;
        logic erase_err;
        logic prog_err;
        logic vpp_err;
        logic prog_susp;
        logic lock_err;
        logic bufprog;
    } status_t;

    typedef struct packed {
        logic busy;
        logic erase_susp;
        logic prog_susp;
        logic bufprog;
    } live_flags_t;

    localparam status_t STATUS_RESET = 8'h80;

    // error vector order: [3] erase, [2] program, [1] supply, [0] lock
    function automatic status_t build_status(live_flags_t lf, logic [ERR_N-1:0] err);
        status_t s;
        s.ready      = ~lf.busy;
        s.erase_susp = lf.erase_susp;
        s.erase_err  = err[3];
        s.prog_err   = err[2];
        s.vpp_err    = err[1];
        s.prog_susp  = lf.prog_susp;
        s.lock_err   = err[0];
        s.bufprog    = lf.bufprog;
        return s;
    endfunction

    function automatic logic is_setup_code(logic [7:0] c);
        return (c == CMD_WORD_PROG) || (c == CMD_BLOCK_ERASE) || (c == CMD_LOCK_SETUP);
    endfunction

endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
    import flash_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_wr,
    input  logic [7:0] cmd_data,
    output rd_mode_e mode,
    output logic     clr_status
);

    seq_state_e seq_q, seq_d;
    rd_mode_e   mode_q, mode_d;

    always_comb begin
        seq_d      = seq_q;
        mode_d     = mode_q;
        clr_status = 1'b0;
        if (cmd_wr) begin
            if (seq_q != SEQ_IDLE) begin
                seq_d  = SEQ_IDLE;
                mode_d = MODE_STATUS;
            end else begin
                case (cmd_data)
                    CMD_READ_ARRAY:   mode_d = MODE_ARRAY;
                    CMD_READ_STATUS:  mode_d = MODE_STATUS;
                    CMD_WORD_PROG:    seq_d  = SEQ_PROG;
                    CMD_BLOCK_ERASE:  seq_d  = SEQ_ERASE;
                    CMD_LOCK_SETUP:   seq_d  = SEQ_LOCK;
                    CMD_CLEAR_STATUS: clr_status = 1'b1;
                    default:          ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SEQ_IDLE;
            mode_q <= MODE_ARRAY;
        end else begin
            seq_q  <= seq_d;
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    AST_STATUS_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && seq_q == SEQ_IDLE && cmd_data == CMD_READ_STATUS) |=> mode_q == MODE_STATUS); // R2

    AST_ARRAY_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && seq_q == SEQ_IDLE && cmd_data == CMD_READ_ARRAY) |=> mode_q == MODE_ARRAY); // R2

    AST_SEQ_DONE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && seq_q != SEQ_IDLE) |=> (mode_q == MODE_STATUS && seq_q == SEQ_IDLE)); // R3

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && seq_q == SEQ_IDLE && cmd_data != CMD_READ_ARRAY && cmd_data != CMD_READ_STATUS)
        |=> $stable(mode_q)); // R4

endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
    import flash_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  live_flags_t       live,
    input  logic [ERR_N-1:0]  err_set,
    input  logic              clr,
    input  logic              latch,
    output status_t           snap
);

    logic [ERR_N-1:0] sticky_q;
    status_t          snap_q;

    for (genvar gi = 0; gi < ERR_N; gi++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst)
                sticky_q[gi] <= 1'b0;
            else if (err_set[gi])
                sticky_q[gi] <= 1'b1;
            else if (clr)
                sticky_q[gi] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= STATUS_RESET;
        else if (latch)
            snap_q <= build_status(live, sticky_q);
    end

    assign snap = snap_q;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(snap_q)); // R9

    AST_CLEAR_ERRS: assert property (@(posedge clk) disable iff (rst)
        (clr && err_set == '0) |=> sticky_q == '0); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr && err_set != '0) |=> ((sticky_q & $past(err_set)) == $past(err_set))); // R6

endmodule

// File: rtl/flash_rd_trig.sv
module flash_rd_trig (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic ce_n,
    input  logic oe_n,
    input  logic adv_n,
    output logic latch,
    output logic burst_start,
    output logic burst_abort
);

    logic ce_q, oe_q, adv_q;
    logic async_latch, sync_latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q  <= 1'b1;
            oe_q  <= 1'b1;
            adv_q <= 1'b1;
        end else begin
            ce_q  <= ce_n;
            oe_q  <= oe_n;
            adv_q <= adv_n;
        end
    end

    // access begins: both strobes were idle, at least one now active
    assign async_latch = !sync_mode && ce_q && oe_q && !(ce_n && oe_n);
    assign sync_latch  = sync_mode && ((ce_q && !ce_n) || (adv_q && !adv_n));
    assign latch       = async_latch || sync_latch;
    assign burst_start = sync_mode && !ce_n && adv_q && !adv_n;
    assign burst_abort = ce_n;

    AST_NO_LATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ce_n && oe_n && adv_n) |-> !latch); // R7

    AST_ASYNC_ONCE: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && !(ce_q && oe_q)) |-> !latch); // R7

endmodule

// File: rtl/flash_burst_ctr.sv
module flash_burst_ctr #(
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic active,
    output logic done
);

    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                cnt_q    <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (abort) begin
                    active_q <= 1'b0;
                end else if (cnt_q == LAST) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign active = active_q;
    assign done   = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10

    AST_DONE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(active_q)); // R10

    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (active_q && abort && !start) |=> (!done_q && !active_q)); // R11

endmodule

// File: rtl/flash_rdctl.sv
module flash_rdctl
    import flash_rd_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                PAGE_W    = 2,
    parameter int                BURST_LEN = 8,
    parameter logic [DATA_W-1:0] PAGE_FILL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic              busy_in,
    input  logic              erase_susp_in,
    input  logic              prog_susp_in,
    input  logic              bufprog_in,
    input  logic              erase_err_set,
    input  logic              prog_err_set,
    input  logic              vpp_err_set,
    input  logic              lock_err_set,
    input  logic              sync_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [PAGE_W-1:0] page_idx,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] data_out,
    output logic              status_mode,
    output logic              burst_active,
    output logic              burst_done
);

    localparam int PAD_W = DATA_W - STAT_W;

    rd_mode_e         mode;
    logic             clr_status;
    logic             latch, burst_start, burst_abort;
    status_t          snap;
    live_flags_t      live;
    logic [ERR_N-1:0] err_set;
    logic [DATA_W-1:0] status_word;
    logic             filler_sel;

    assign live    = '{busy: busy_in, erase_susp: erase_susp_in,
                       prog_susp: prog_susp_in, bufprog: bufprog_in};
    assign err_set = {erase_err_set, prog_err_set, vpp_err_set, lock_err_set};

    flash_cmd_dec u_cmd (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_data   (cmd_data),
        .mode       (mode),
        .clr_status (clr_status)
    );

    flash_rd_trig u_trig (
        .clk         (clk),
        .rst         (rst),
        .sync_mode   (sync_mode),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .adv_n       (adv_n),
        .latch       (latch),
        .burst_start (burst_start),
        .burst_abort (burst_abort)
    );

    flash_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .live    (live),
        .err_set (err_set),
        .clr     (clr_status),
        .latch   (latch),
        .snap    (snap)
    );

    flash_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk    (clk),
        .rst    (rst),
        .start  (burst_start),
        .abort  (burst_abort),
        .active (burst_active),
        .done   (burst_done)
    );

    assign status_word = {{PAD_W{1'b0}}, snap};
    assign filler_sel  = !sync_mode && (page_idx != '0);

    always_comb begin
        if (mode == MODE_ARRAY)
            data_out = array_data;
        else if (filler_sel)
            data_out = PAGE_FILL;
        else
            data_out = status_word;
    end

    assign status_mode = (mode == MODE_STATUS);

    AST_BURST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (burst_active && status_mode && !latch && !cmd_wr) |=> $stable(data_out)); // R10

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!status_mode && !burst_active && !burst_done)); // R1

endmodule

// File: tb/test_flash_rdctl.sv
module test_flash_rdctl;
    localparam int BL = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 0;
    logic [7:0]  cmd_data = 0;
    logic        busy_in = 0, erase_susp_in = 0, prog_susp_in = 0, bufprog_in = 0;
    logic        erase_err_set = 0, prog_err_set = 0, vpp_err_set = 0, lock_err_set = 0;
    logic        sync_mode = 0, ce_n = 1, oe_n = 1, adv_n = 1;
    logic [1:0]  page_idx = 0;
    logic [15:0] array_data = 16'h1234;
    logic [15:0] data_out;
    logic        status_mode, burst_active, burst_done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flash_rdctl #(.BURST_LEN(BL)) i_flash_rdctl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .busy_in(busy_in), .erase_susp_in(erase_susp_in), .prog_susp_in(prog_susp_in),
        .bufprog_in(bufprog_in), .erase_err_set(erase_err_set), .prog_err_set(prog_err_set),
        .vpp_err_set(vpp_err_set), .lock_err_set(lock_err_set), .sync_mode(sync_mode),
        .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n), .page_idx(page_idx),
        .array_data(array_data), .data_out(data_out), .status_mode(status_mode),
        .burst_active(burst_active), .burst_done(burst_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] c);
        cmd_wr = 1'b1; cmd_data = c;
        tick();
        cmd_wr = 1'b0;
    endtask

    task automatic async_read(input logic [1:0] pg, output logic [15:0] d);
        ce_n = 1'b0; oe_n = 1'b0; page_idx = pg;
        tick();
        d = data_out;
        ce_n = 1'b1; oe_n = 1'b1; page_idx = 0;
        tick();
    endtask

    function automatic logic [7:0] exp_status(input logic b, es, ps, bp, input logic [3:0] e);
        return {~b, es, e[3], e[2], e[1], ps, e[0], bp};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] held;
        int act_cnt, done_at, mode_exp;

        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 mode", status_mode, 0);
        chk("R1 burst", burst_active, 0);
        chk("R12 array pass", data_out, 16'h1234);
        wr(8'h70);
        ce_n = 1'b0; tick(); // snapshot never refreshed yet would still show 0x80
        chk("R1 snapshot", data_out, 16'h0080);
        ce_n = 1'b1; tick();

        // R2 R3 R4 command sweep from both modes
        for (int sm = 0; sm < 2; sm++) begin
            for (int c = 0; c < 256; c++) begin
                wr(sm ? 8'h70 : 8'hFF);
                wr(8'(c));
                if (c == 8'h40 || c == 8'h20 || c == 8'h60) begin
                    chk("R3 setup holds mode", status_mode, 32'(sm));
                    wr(8'h00);
                    mode_exp = 1;
                end else if (c == 8'hFF) mode_exp = 0;
                else if (c == 8'h70) mode_exp = 1;
                else mode_exp = sm;
                if (c == 8'h70 || c == 8'hFF) chk("R2 mode cmd", status_mode, 32'(mode_exp));
                else if (mode_exp == 1 && sm == 0) chk("R3 sequence status", status_mode, 32'(mode_exp));
                else chk("R4 mode unchanged", status_mode, 32'(mode_exp));
            end
        end

        // R5 live flag sweep
        wr(8'h70);
        for (int v = 0; v < 16; v++) begin
            {busy_in, erase_susp_in, prog_susp_in, bufprog_in} = 4'(v);
            tick();
            async_read(0, d);
            chk("R5 status layout", d, {8'h00, exp_status(v[3], v[2], v[1], v[0], 4'h0)});
        end
        {busy_in, erase_susp_in, prog_susp_in, bufprog_in} = 4'h0;

        // R6 sticky errors, each alone then together
        for (int b = 0; b < 4; b++) begin
            {erase_err_set, prog_err_set, vpp_err_set, lock_err_set} = 4'(1 << b);
            tick();
            {erase_err_set, prog_err_set, vpp_err_set, lock_err_set} = 4'h0;
            tick(2);
            async_read(0, d);
            chk("R6 sticky set", d, {8'h00, exp_status(0, 0, 0, 0, 4'(1 << b))});
            wr(8'h50);
            chk("R4 clear keeps mode", status_mode, 1);
            async_read(0, d);
            chk("R6 clear", d, 16'h0080);
        end
        {erase_err_set, prog_err_set, vpp_err_set, lock_err_set} = 4'hF;
        tick();
        {erase_err_set, prog_err_set, vpp_err_set, lock_err_set} = 4'h0;
        async_read(0, d);
        chk("R6 all errors", d, 16'h00BA);
        // set and clear in the same cycle: set wins
        lock_err_set = 1'b1; cmd_wr = 1'b1; cmd_data = 8'h50;
        tick();
        lock_err_set = 1'b0; cmd_wr = 1'b0;
        async_read(0, d);
        chk("R6 set beats clear", d, 16'h0082);
        wr(8'h50);

        // R7 only the first falling strobe refreshes
        ce_n = 1'b0; tick();
        busy_in = 1'b1; tick(2);
        oe_n = 1'b0; tick(2);
        chk("R7 second strobe ignored", data_out, 16'h0080);
        ce_n = 1'b1; oe_n = 1'b1; tick();
        oe_n = 1'b0; tick();
        chk("R7 new access refresh", data_out, 16'h0000);
        oe_n = 1'b1; busy_in = 1'b0; tick();

        // R8 page filler
        for (int p = 0; p < 4; p++) begin
            async_read(2'(p), d);
            chk("R8 page word", d, p == 0 ? 16'h0080 : 16'hFFFF);
        end
        // R12 array mode ignores page index
        wr(8'hFF);
        for (int p = 0; p < 4; p++) begin
            array_data = 16'hA500 + 16'(p);
            page_idx = 2'(p); tick();
            chk("R12 array data", data_out, 16'hA500 + 16'(p));
        end
        page_idx = 0;
        wr(8'h70);

        // R9 R10 synchronous burst
        sync_mode = 1'b1; tick();
        ce_n = 1'b0; tick();
        chk("R9 ce fall refresh", data_out, 16'h0080);
        busy_in = 1'b1; tick(2);
        chk("R9 no edge no refresh", data_out, 16'h0080);
        page_idx = 2'd3; tick();
        chk("R9 page ignored", data_out, 16'h0080);
        page_idx = 0;
        adv_n = 1'b0;
        act_cnt = 0; done_at = 0;
        tick();
        held = data_out;
        chk("R9 adv fall refresh", held, 16'h0000);
        busy_in = 1'b0;
        for (int k = 1; k <= BL + 3; k++) begin
            if (burst_active) begin
                act_cnt++;
                chk("R10 word repeated", data_out, held);
            end
            if (burst_done) done_at = k;
            tick();
        end
        chk("R10 active length", act_cnt, BL);
        chk("R10 done position", done_at, BL + 1);
        adv_n = 1'b1; tick();
        adv_n = 1'b0; tick();
        chk("R9 adv toggle refresh", data_out, 16'h0080);
        adv_n = 1'b1;
        // R11 abort
        tick(2);
        adv_n = 1'b0; tick(2);
        chk("R11 burst running", burst_active, 1);
        ce_n = 1'b1; tick();
        chk("R11 aborted", burst_active, 0);
        done_at = 0;
        for (int k = 0; k < BL + 2; k++) begin
            if (burst_done) done_at = 1;
            tick();
        end
        chk("R11 no done", done_at, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule